// File: doc/BRIEF.md
# Dual-Branch Glitch-Free Clock Root Slice

This block builds one clock root from eight candidate input clocks. It has two parallel branches, A and B. Each branch has its own 3-bit source selector, its own gate and its own integer pre-divider. A single toggle decides which branch is active. The active branch feeds a shared post-divider, and the post-divider produces the root output. Software does not program the branches directly. It issues target commands, and each command carries a source number, a gate enable, a pre-divide value and a post-divide value.

Each command is applied to the branch that is currently idle. The handshake then gates the outgoing branch off, flips the toggle, and gates the incoming branch on. Each gate is re-timed through a two-flop synchronizer, and the next step waits for the synchronized gate to acknowledge. As a result, the two branches are never gated on together. Writing the same source twice puts both branches on that source. After that, a later change does not depend on the old source, even if that source has been stopped.

Inside the block, the inputs and the output are enable-qualified ticks of one reference clock. Each input clock is one tick pulse, and the output clock is the tick pulse `root_tick`. Each input also has a running-status line. The block rejects any command whose source is not running. A debug view brings out both branch selectors and the toggle.

Top module: `clkroot_slice`

## Requirements
- R1: After reset, both selectors hold source 0, branch A is active (`act_b`=0), and the active gate is on. Both divide values are 0, so the ratio is 1, and `busy` and `fault` are low.
- R2: A command loads its source into the idle branch (B when `act_b`=0, A when `act_b`=1) and then makes that branch active. The other branch's selector does not change.
- R3: Writing the same source twice leaves both selectors on that source. A later change to a third source then completes without a fault, even after the first source has stopped running.
- R4: In steady state, the interval between `root_tick` pulses equals (input period) × (pre+1) × (post+1) reference cycles.
- R5: When `PRE_ON`=0, the pre-divide field has no effect, and the interval becomes (input period) × (post+1).
- R6: `busy` is high from the cycle after a command is accepted until its switch-over is finished. Commands that arrive while busy are queued and applied in arrival order.
- R7: A command whose source has a low synchronized running status sets `fault`. Such a command changes neither selector nor the toggle. `fault` is cleared by the next command that is accepted.
- R8: A command with gate enable 0 stops `root_tick` entirely once its switch-over completes.
- R9: The effective gates of the two branches are never on in the same cycle, and the toggle flips only in the swap step of the handshake.
- R10: A new post-divide value is adopted only when the post counter wraps, so the counter never exceeds the value in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 8 | One pulse per edge of each input clock |
| src_run | input | 8 | Running status of each input clock (asynchronous) |
| wr_en | input | 1 | Target command strobe |
| wr_src | input | 3 | Requested source, 0 to 7 |
| wr_gate | input | 1 | Requested gate enable |
| wr_pre | input | 3 | Pre-divide value N (ratio N+1) |
| wr_post | input | 6 | Post-divide value N (ratio N+1) |
| busy | output | 1 | A command is queued or a switch-over is in progress |
| fault | output | 1 | The last command targeted a stopped source |
| act_b | output | 1 | Debug: 1 when branch B is active |
| sel_a | output | 3 | Debug: branch A source selector |
| sel_b | output | 3 | Debug: branch B source selector |
| root_tick | output | 1 | One pulse per output clock edge |

## Verification
The queue assertion assumes that `wr_en` never arrives while the queue already holds `QDEPTH` commands. The stimulus never has more than three commands outstanding.

The branch and handshake assertions assume that `src_run` is stable long enough for the synchronizer to see it. After each change to `src_run`, the stimulus waits several cycles before it issues the next command.

Periods are measured only after the switch-over has finished and a few output pulses have passed. The post counter's leftover count from the previous setting is then gone. The random stimulus always keeps every source running, so that random commands exercise the period ratio rather than the rejection path.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    localparam int NSRC   = 8;
    localparam int SEL_W  = $clog2(NSRC);
    localparam int PRE_W  = 3;
    localparam int POST_W = 6;

    // One target command as queued by the controller.
    typedef struct packed {
        logic [SEL_W-1:0]  src;
        logic              gate;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } tgt_cmd_t;

    // Switch-over handshake steps.
    typedef enum logic [1:0] {
        SW_IDLE,
        SW_DRAIN,
        SW_SWAP,
        SW_FILL
    } sw_state_e;

    // Branch index: 0 = A, 1 = B.
    function automatic logic peer(input logic b);
        return ~b;
    endfunction

endpackage

// File: rtl/clkroot_sync.sv
module clkroot_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/clkroot_branch.sv
module clkroot_branch
    import clkroot_pkg::*;
#(
    parameter bit PRE_ON   = 1'b1,
    parameter bit GATE_RST = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src_tick,
    input  logic [SEL_W-1:0]    sel,
    input  logic [PRE_W-1:0]    pre_n,
    input  logic                gate_req,
    input  logic                restart,
    output logic                gate_on,
    output logic                pre_tick
);

    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] cnt;
    logic             gated;

    clkroot_sync #(.W(1), .RST_VAL(GATE_RST)) u_gate_sync (
        .clk (clk),
        .rst (rst),
        .d   (gate_req),
        .q   (gate_on)
    );

    // A core-style slice has no pre-divide stage: the limit is forced to zero.
    assign limit = PRE_ON ? pre_n : '0;
    assign gated = src_tick[sel] & gate_on;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt      <= '0;
            pre_tick <= 1'b0;
        end else begin
            pre_tick <= 1'b0;
            if (gated) begin
                if (cnt >= limit) begin
                    cnt      <= '0;
                    pre_tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_on && $past(gate_on)) |-> $stable(sel));

endmodule

// File: rtl/clkroot_post.sv
module clkroot_post
    import clkroot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_tick,
    input  logic [POST_W-1:0] post_n,
    output logic              out_tick
);

    logic [POST_W-1:0] cur;
    logic [POST_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            cnt      <= '0;
            out_tick <= 1'b0;
        end else begin
            out_tick <= 1'b0;
            if (in_tick) begin
                if (cnt >= cur) begin
                    cnt      <= '0;
                    cur      <= post_n;
                    out_tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10
    post_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= cur);

    // R10
    post_wrap_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur) |-> (cnt == '0));

endmodule

// File: rtl/clkroot_ctrl.sv
module clkroot_ctrl
    import clkroot_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  tgt_cmd_t                     wr_cmd,
    input  logic [NSRC-1:0]              run_ok,
    input  logic [1:0]                   gate_on,
    output logic [1:0][SEL_W-1:0]        sel_q,
    output logic [1:0][PRE_W-1:0]        pre_q,
    output logic [1:0]                   gate_q,
    output logic [1:0]                   restart,
    output logic                         act,
    output logic [POST_W-1:0]            post_q,
    output logic                         busy,
    output logic                         fault
);

    localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CNT_W = $clog2(QDEPTH + 1);

    tgt_cmd_t          fifo [QDEPTH];
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  rp;
    logic [CNT_W-1:0]  cnt;
    tgt_cmd_t          head;
    logic              pop;
    sw_state_e         state;
    logic              cur_gate;
    logic [POST_W-1:0] cur_post;
    logic              idle_b;

    assign head   = fifo[rp];
    assign pop    = (state == SW_IDLE) && (cnt != '0);
    assign busy   = (cnt != '0) || (state != SW_IDLE);
    assign idle_b = peer(act);

    // Command queue, applied strictly in order.
    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) begin
                fifo[wp] <= wr_cmd;
                wp       <= (wp == PTR_W'(QDEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == PTR_W'(QDEPTH - 1)) ? '0 : rp + 1'b1;
            end
            cnt <= cnt + CNT_W'(wr_en) - CNT_W'(pop);
        end
    end

    // Switch-over handshake.
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SW_IDLE;
            act      <= 1'b0;
            sel_q    <= '0;
            pre_q    <= '0;
            gate_q   <= 2'b01;
            restart  <= 2'b00;
            post_q   <= '0;
            fault    <= 1'b0;
            cur_gate <= 1'b0;
            cur_post <= '0;
        end else begin
            restart <= 2'b00;
            unique case (state)
                SW_IDLE: begin
                    if (cnt != '0) begin
                        if (!run_ok[head.src]) begin
                            fault <= 1'b1;
                        end else begin
                            fault           <= 1'b0;
                            sel_q[idle_b]   <= head.src;
                            pre_q[idle_b]   <= head.pre;
                            restart[idle_b] <= 1'b1;
                            gate_q[act]     <= 1'b0;
                            cur_gate        <= head.gate;
                            cur_post        <= head.post;
                            state           <= SW_DRAIN;
                        end
                    end
                end
                SW_DRAIN: begin
                    if (!gate_on[act]) state <= SW_SWAP;
                end
                SW_SWAP: begin
                    act            <= idle_b;
                    gate_q[idle_b] <= cur_gate;
                    post_q         <= cur_post;
                    state          <= SW_FILL;
                end
                SW_FILL: begin
                    if (gate_on[act] == gate_q[act]) state <= SW_IDLE;
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (cnt != CNT_W'(QDEPTH)));

    // R9
    flip_in_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> $past(state == SW_SWAP));

    // R7
    fault_no_flip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> ($stable(act) && $stable(sel_q)));

endmodule

// File: rtl/clkroot_slice.sv
module clkroot_slice
    import clkroot_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter bit PRE_ON = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        src_tick,
    input  logic [7:0]        src_run,
    input  logic              wr_en,
    input  logic [2:0]        wr_src,
    input  logic              wr_gate,
    input  logic [2:0]        wr_pre,
    input  logic [5:0]        wr_post,
    output logic              busy,
    output logic              fault,
    output logic              act_b,
    output logic [2:0]        sel_a,
    output logic [2:0]        sel_b,
    output logic              root_tick
);

    tgt_cmd_t                 cmd;
    logic [NSRC-1:0]          run_ok;
    logic [1:0][SEL_W-1:0]    sel_q;
    logic [1:0][PRE_W-1:0]    pre_q;
    logic [1:0]               gate_q;
    logic [1:0]               restart;
    logic [1:0]               gate_on;
    logic [1:0]               pre_tick;
    logic [POST_W-1:0]        post_q;
    logic                     act;

    assign cmd = '{src: wr_src, gate: wr_gate, pre: wr_pre, post: wr_post};

    clkroot_sync #(.W(NSRC), .RST_VAL('0)) u_run_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_run),
        .q   (run_ok)
    );

    clkroot_ctrl #(.QDEPTH(QDEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_cmd  (cmd),
        .run_ok  (run_ok),
        .gate_on (gate_on),
        .sel_q   (sel_q),
        .pre_q   (pre_q),
        .gate_q  (gate_q),
        .restart (restart),
        .act     (act),
        .post_q  (post_q),
        .busy    (busy),
        .fault   (fault)
    );

    for (genvar g = 0; g < 2; g++) begin : g_branch
        clkroot_branch #(.PRE_ON(PRE_ON), .GATE_RST(g == 0)) u_branch (
            .clk      (clk),
            .rst      (rst),
            .src_tick (src_tick),
            .sel      (sel_q[g]),
            .pre_n    (pre_q[g]),
            .gate_req (gate_q[g]),
            .restart  (restart[g]),
            .gate_on  (gate_on[g]),
            .pre_tick (pre_tick[g])
        );
    end

    clkroot_post u_post (
        .clk      (clk),
        .rst      (rst),
        .in_tick  (act ? pre_tick[1] : pre_tick[0]),
        .post_n   (post_q),
        .out_tick (root_tick)
    );

    assign act_b = act;
    assign sel_a = sel_q[0];
    assign sel_b = sel_q[1];

    // R9
    break_before_make_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_on[0] && gate_on[1]));

endmodule

// File: tb/clkroot_slice_tb.sv
module clkroot_slice_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_tick = '0;
    logic [7:0] src_run = '1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_src = '0;
    logic       wr_gate = 1'b0;
    logic [2:0] wr_pre = '0;
    logic [5:0] wr_post = '0;
    logic       busy, fault, act_b, root_tick;
    logic [2:0] sel_a, sel_b;
    logic       c_busy, c_fault, c_act, c_tick;
    logic [2:0] c_sa, c_sb;

    int n_chk = 0;
    int n_fail = 0;
    int exp_act = 0;
    int exp_a = 0;
    int exp_b = 0;

    always #2 clk = ~clk;

    clkroot_slice u_dut (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_run(src_run),
        .wr_en(wr_en), .wr_src(wr_src), .wr_gate(wr_gate), .wr_pre(wr_pre),
        .wr_post(wr_post), .busy(busy), .fault(fault), .act_b(act_b),
        .sel_a(sel_a), .sel_b(sel_b), .root_tick(root_tick)
    );

    clkroot_slice #(.PRE_ON(1'b0)) u_core (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_run(src_run),
        .wr_en(wr_en), .wr_src(wr_src), .wr_gate(wr_gate), .wr_pre(wr_pre),
        .wr_post(wr_post), .busy(c_busy), .fault(c_fault), .act_b(c_act),
        .sel_a(c_sa), .sel_b(c_sb), .root_tick(c_tick)
    );

    // Input i ticks once every i+2 reference cycles.
    initial begin
        int cnt [8];
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                if (cnt[i] == i + 1) begin
                    cnt[i] = 0;
                    src_tick[i] = 1'b1;
                end else begin
                    cnt[i] = cnt[i] + 1;
                    src_tick[i] = 1'b0;
                end
            end
        end
    end

    function automatic int exp_per(int src, int pre, int post, bit core);
        return (src + 2) * (core ? 1 : pre + 1) * (post + 1);
    endfunction

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic cmd_push(int src, bit gate, int pre, int post);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_src  = 3'(src);
        wr_gate = gate;
        wr_pre  = 3'(pre);
        wr_post = 6'(post);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Bench model of an accepted command: idle branch loaded, then swapped in.
    task automatic model_apply(int src);
        if (exp_act == 0) exp_b = src;
        else exp_a = src;
        exp_act = 1 - exp_act;
    endtask

    task automatic chk_state(string req);
        chk(req, int'(act_b), exp_act);
        chk(req, int'(sel_a), exp_a);
        chk(req, int'(sel_b), exp_b);
    endtask

    task automatic measure(bit core, output int per);
        int n;
        n = 0;
        while (n < 3) begin
            @(negedge clk);
            if (core ? c_tick : root_tick) n++;
        end
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!(core ? c_tick : root_tick));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int per;
        int cnt;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state and ratio-1 output on source 0
        chk("R1 busy", int'(busy), 0);
        chk("R1 fault", int'(fault), 0);
        chk_state("R1");
        measure(1'b0, per);
        chk("R1 period", per, exp_per(0, 0, 0, 1'b0));

        // R2: first write of source 1 lands in B, A keeps source 0
        cmd_push(1, 1'b1, 0, 0);
        chk("R6 busy after write", int'(busy), 1);
        wait_idle();
        model_apply(1);
        chk_state("R2");

        // R3: second write of source 1 puts both branches on it
        cmd_push(1, 1'b1, 0, 0);
        wait_idle();
        model_apply(1);
        chk_state("R3");

        // R3: source 0 stops; switching to 2 must still work
        src_run[0] = 1'b0;
        repeat (6) @(negedge clk);
        cmd_push(2, 1'b1, 1, 2);
        wait_idle();
        model_apply(2);
        chk_state("R3 after stop");
        chk("R3 fault", int'(fault), 0);
        measure(1'b0, per);
        chk("R4 period", per, exp_per(2, 1, 2, 1'b0));
        measure(1'b1, per);
        chk("R5 core period", per, exp_per(2, 1, 2, 1'b1));

        // R7: stopped source is rejected without touching branches
        src_run[5] = 1'b0;
        repeat (6) @(negedge clk);
        cmd_push(5, 1'b1, 0, 0);
        wait_idle();
        chk("R7 fault set", int'(fault), 1);
        chk_state("R7 unchanged");
        cmd_push(3, 1'b1, 0, 1);
        wait_idle();
        model_apply(3);
        chk("R7 fault cleared", int'(fault), 0);
        chk_state("R7 next");
        measure(1'b0, per);
        chk("R4 period", per, exp_per(3, 0, 1, 1'b0));

        // R6: back-to-back writes queue up and apply in order
        cmd_push(4, 1'b1, 0, 0);
        cmd_push(6, 1'b1, 0, 0);
        cmd_push(7, 1'b1, 0, 0);
        chk("R6 busy queued", int'(busy), 1);
        wait_idle();
        model_apply(4);
        model_apply(6);
        model_apply(7);
        chk_state("R6 order");
        measure(1'b0, per);
        chk("R6 period", per, exp_per(7, 0, 0, 1'b0));

        // R8: gate disabled stops the output
        cmd_push(2, 1'b0, 0, 0);
        wait_idle();
        model_apply(2);
        chk_state("R8");
        cnt = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (root_tick) cnt++;
        end
        chk("R8 no ticks", cnt, 0);
        cmd_push(4, 1'b1, 0, 0);
        wait_idle();
        model_apply(4);
        measure(1'b0, per);
        chk("R8 reopen period", per, exp_per(4, 0, 0, 1'b0));

        // Random commands with every source running
        src_run = '1;
        repeat (6) @(negedge clk);
        void'($urandom(32'h00c1_0c55));
        for (int k = 0; k < 10; k++) begin
            int s, p, q;
            s = int'($urandom_range(7, 0));
            p = int'($urandom_range(7, 0));
            q = int'($urandom_range(15, 0));
            cmd_push(s, 1'b1, p, q);
            wait_idle();
            model_apply(s);
            chk_state("R2 random");
            measure(1'b0, per);
            chk("R4 random period", per, exp_per(s, p, q, 1'b0));
            if (k % 3 == 0) begin
                measure(1'b1, per);
                chk("R5 random core period", per, exp_per(s, p, q, 1'b1));
            end
        end

        finish_run();
    end

endmodule